// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit sits beside the execute stage of a single-cycle 64-bit RISC-V core. It decides where the next instruction comes from. It takes four inputs:

- a two-bit transfer code from the main decoder;
- the two register operands;
- the three-bit funct3 field;
- the current PC and the immediate, which arrives already sign-extended and scaled.

From these it produces the next PC and a separate taken flag. One unit handles both unconditional jumps and the six conditional branches, so the PC register loads `next_pc` on every cycle without a separate mux.

Every output is a pure function of the present inputs. Nothing is registered and there is no handshake, so the unit never asserts back-pressure. The decoder presents an instruction and the result settles within the same cycle. The transfer code is 0 for no transfer, 1 for jal, 2 for jalr and 3 for a conditional branch.

Top module: `npc_branch_unit`

## Requirements
- R1: With transfer code 0, `next_pc` equals `cur_pc + 4` and `taken` is low, whatever the operands and funct3 hold.
- R2: With transfer code 1 (jal), `next_pc` equals `cur_pc + imm` and `taken` is high, independent of operands and funct3.
- R3: With transfer code 2 (jalr), `next_pc` equals `src_a + imm` with bit 0 cleared, and `taken` is high.
- R4: With transfer code 3, funct3 000 branches when `src_a == src_b`, and funct3 001 branches when they differ.
- R5: With transfer code 3, funct3 100 branches when `src_a < src_b` as two's-complement values, and funct3 101 branches when `src_a >= src_b` as two's-complement values.
- R6: With transfer code 3, funct3 110 branches when `src_a < src_b` as unsigned values, and funct3 111 branches when `src_a >= src_b` as unsigned values.
- R7: For a branch whose condition holds, `next_pc = cur_pc + imm` and `taken` is high. When the condition fails, `next_pc = cur_pc + 4` and `taken` is low.
- R8: With transfer code 3, funct3 values 010 and 011 never branch: `next_pc = cur_pc + 4` and `taken` is low.
- R9: All sums (fall-through, PC-relative target, register-relative target) wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xfer_op | input | 2 | Transfer code: 0 none, 1 jal, 2 jalr, 3 branch |
| src_a | input | 64 | First register operand (jalr base, left comparand) |
| src_b | input | 64 | Second register operand (right comparand) |
| funct3 | input | 3 | Branch condition selector |
| cur_pc | input | 64 | Address of the current instruction |
| imm | input | 64 | Sign-extended, pre-scaled immediate |
| next_pc | output | 64 | Address of the next instruction |
| taken | output | 1 | High for any jump, or for a branch whose condition holds |

## Verification
The condition evaluator and the target adders work in the same cycle. The final select must let the transfer code override the comparator result. The bench provokes this with operand pairs that would satisfy the condition selected by funct3, presented under transfer codes 0, 1 and 2. It judges the outcome by checking that `next_pc` and `taken` follow only the transfer code. Operands that straddle the sign boundary, such as all-ones against zero and the most negative value against the most positive, drive the signed and unsigned paths to opposite answers within a single evaluation.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_JAL    = 2'd1,
    XFER_JALR   = 2'd2,
    XFER_BRANCH = 2'd3
  } xfer_op_e;

  // Branch condition selectors (funct3 field)
  localparam logic [2:0] CND_EQ  = 3'b000;
  localparam logic [2:0] CND_NE  = 3'b001;
  localparam logic [2:0] CND_LT  = 3'b100;
  localparam logic [2:0] CND_GE  = 3'b101;
  localparam logic [2:0] CND_LTU = 3'b110;
  localparam logic [2:0] CND_GEU = 3'b111;

  // Raw comparison flags, shared by every condition
  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;

  // funct3 bit 0 inverts the base relation; bits 2:1 pick the relation.
  function automatic logic cond_from_flags(input cmp_flags_t f, input logic [2:0] sel);
    logic base;
    logic known;
    known = 1'b1;
    unique case (sel[2:1])
      2'b00:   base = f.eq;
      2'b10:   base = f.lt_s;
      2'b11:   base = f.lt_u;
      default: begin
        base  = 1'b0;
        known = 1'b0;
      end
    endcase
    return known & (base ^ sel[0]);
  endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit CMP_SHARED = 1'b1   // 1: one subtractor feeds all flags; 0: separate comparators
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [2:0]      sel,
  output logic            holds
);

  localparam int MSB = XLEN - 1;

  cmp_flags_t flags;

  generate
    if (CMP_SHARED) begin : g_shared
      logic [XLEN:0] diff;
      logic          sign_mix;
      always_comb begin
        diff       = {1'b0, lhs} - {1'b0, rhs};
        sign_mix   = lhs[MSB] ^ rhs[MSB];
        flags.eq   = (diff[XLEN-1:0] == '0);
        flags.lt_u = diff[XLEN];
        // Differing signs: the negative side is smaller. Same signs: no overflow, use result sign.
        flags.lt_s = sign_mix ? lhs[MSB] : diff[MSB];
      end
    end else begin : g_direct
      always_comb begin
        flags.eq   = (lhs == rhs);
        flags.lt_u = (lhs < rhs);
        flags.lt_s = ($signed(lhs) < $signed(rhs));
      end
    end
  endgenerate

  always_comb holds = cond_from_flags(flags, sel);

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] offset,
  input  logic            reg_relative,
  output logic [XLEN-1:0] jump_tgt,
  output logic [XLEN-1:0] fall_tgt
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] raw_sum;

  always_comb begin
    base     = reg_relative ? base_reg : pc;
    raw_sum  = base + offset;                 // wraps modulo 2^XLEN
    jump_tgt = reg_relative ? {raw_sum[XLEN-1:1], 1'b0} : raw_sum;
    fall_tgt = pc + STEP;
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  xfer_op_e        op,
  input  logic            cond_ok,
  input  logic [XLEN-1:0] jump_tgt,
  input  logic [XLEN-1:0] fall_tgt,
  output logic [XLEN-1:0] next_pc,
  output logic            taken
);

  always_comb begin
    unique case (op)
      XFER_JAL, XFER_JALR: taken = 1'b1;
      XFER_BRANCH:         taken = cond_ok;
      default:             taken = 1'b0;
    endcase
    next_pc = taken ? jump_tgt : fall_tgt;
  end

endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
  import npc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4,
  parameter bit CMP_SHARED = 1'b1
) (
  input  logic [1:0]      xfer_op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [2:0]      funct3,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] next_pc,
  output logic            taken
);

  xfer_op_e        op;
  logic            cond_ok;
  logic [XLEN-1:0] jump_tgt;
  logic [XLEN-1:0] fall_tgt;

  assign op = xfer_op_e'(xfer_op);

  npc_cond_eval #(
    .XLEN       (XLEN),
    .CMP_SHARED (CMP_SHARED)
  ) u_cond (
    .lhs   (src_a),
    .rhs   (src_b),
    .sel   (funct3),
    .holds (cond_ok)
  );

  npc_target_gen #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
  ) u_tgt (
    .pc           (cur_pc),
    .base_reg     (src_a),
    .offset       (imm),
    .reg_relative (op == XFER_JALR),
    .jump_tgt     (jump_tgt),
    .fall_tgt     (fall_tgt)
  );

  npc_select #(
    .XLEN (XLEN)
  ) u_sel (
    .op       (op),
    .cond_ok  (cond_ok),
    .jump_tgt (jump_tgt),
    .fall_tgt (fall_tgt),
    .next_pc  (next_pc),
    .taken    (taken)
  );

endmodule

// File: rtl/npc_branch_unit_chk.sv
module npc_branch_unit_chk #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input logic [1:0]      xfer_op,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [2:0]      funct3,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] imm,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            cond_ok,
  input logic [XLEN-1:0] jump_tgt
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] pc_step;
  logic [XLEN-1:0] pc_rel;
  logic [XLEN-1:0] reg_rel;

  always_comb begin
    pc_step = cur_pc + STEP;
    pc_rel  = cur_pc + imm;
    reg_rel = src_a + imm;
    if (xfer_op == 2'd0) begin
      AST_IDLE_FALLTHRU: assert (!taken && next_pc == pc_step) else $error("idle transfer moved PC"); // R1
    end
    if (xfer_op == 2'd1) begin
      AST_JAL_TARGET: assert (taken && next_pc == pc_rel) else $error("jal target wrong"); // R2
    end
    if (xfer_op == 2'd2) begin
      AST_JALR_TARGET: assert (taken && next_pc == {reg_rel[XLEN-1:1], 1'b0}) else $error("jalr target wrong"); // R3
    end
    if (xfer_op == 2'd3 && funct3 == 3'b000) begin
      AST_BR_EQ_FLAG: assert (cond_ok == (src_a == src_b)) else $error("equality flag wrong"); // R4
    end
    if (xfer_op == 2'd3 && funct3 == 3'b110) begin
      AST_BR_LTU_FLAG: assert (cond_ok == (src_a < src_b)) else $error("unsigned less-than flag wrong"); // R6
    end
    if (xfer_op == 2'd3) begin
      AST_BR_RESOLVE: assert (taken == cond_ok && next_pc == (cond_ok ? jump_tgt : pc_step))
        else $error("branch resolution inconsistent"); // R7
    end
    if (xfer_op == 2'd3 && funct3[2:1] == 2'b01) begin
      AST_BR_RESERVED: assert (!taken) else $error("reserved condition taken"); // R8
    end
  end

endmodule

bind npc_branch_unit npc_branch_unit_chk #(
  .XLEN       (XLEN),
  .INSN_BYTES (INSN_BYTES)
) u_chk (
  .xfer_op  (xfer_op),
  .src_a    (src_a),
  .src_b    (src_b),
  .funct3   (funct3),
  .cur_pc   (cur_pc),
  .imm      (imm),
  .next_pc  (next_pc),
  .taken    (taken),
  .cond_ok  (cond_ok),
  .jump_tgt (jump_tgt)
);

// File: tb/npc_branch_unit_tb_top.sv
module npc_branch_unit_tb_top;

  localparam int VW = 2 + 3 + 64 * 5 + 1;
  localparam int NV = 19;
  localparam logic [63:0] P  = 64'h1000;
  localparam logic [63:0] I  = 64'h40;
  localparam logic [63:0] TK = 64'h1040;
  localparam logic [63:0] NT = 64'h1004;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;

  // {op, funct3, src_a, src_b, pc, imm, expected next_pc, expected taken}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 3'b000, 64'd5, 64'd5, P, I, NT, 1'b0},
    {2'd1, 3'b111, 64'd1, 64'd2, P, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0FF0, 1'b1},
    {2'd2, 3'b000, 64'h2001, 64'd0, P, 64'h10, 64'h2010, 1'b1},
    {2'd3, 3'b000, 64'd7, 64'd7, P, I, TK, 1'b1},
    {2'd3, 3'b000, 64'd7, 64'd8, P, I, NT, 1'b0},
    {2'd3, 3'b001, 64'd7, 64'd8, P, I, TK, 1'b1},
    {2'd3, 3'b100, ONES, 64'd0, P, I, TK, 1'b1},
    {2'd3, 3'b110, ONES, 64'd0, P, I, NT, 1'b0},
    {2'd3, 3'b101, ONES, 64'd0, P, I, NT, 1'b0},
    {2'd3, 3'b111, ONES, 64'd0, P, I, TK, 1'b1},
    {2'd3, 3'b010, 64'd0, 64'd1, P, I, NT, 1'b0},
    {2'd3, 3'b011, 64'd1, 64'd1, P, I, NT, 1'b0},
    {2'd1, 3'b000, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 64'h10, 1'b1},
    {2'd0, 3'b000, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFC, I, 64'h0, 1'b0},
    {2'd3, 3'b100, SMIN, SMAX, P, I, TK, 1'b1},
    {2'd3, 3'b101, SMAX, SMIN, P, I, TK, 1'b1},
    {2'd3, 3'b110, 64'd0, ONES, P, I, TK, 1'b1},
    {2'd3, 3'b101, 64'd5, 64'd5, P, I, TK, 1'b1},
    {2'd2, 3'b000, ONES, 64'd0, P, 64'd3, 64'd2, 1'b1}
  };
  localparam string TAG [NV] = '{
    "R1", "R2", "R3", "R4", "R4", "R4", "R5", "R6", "R5", "R6",
    "R8", "R8", "R9", "R9", "R5", "R5", "R6", "R7", "R3"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  xfer_op = '0;
  logic [63:0] src_a = '0, src_b = '0, cur_pc = '0, imm = '0;
  logic [2:0]  funct3 = '0;
  logic [63:0] next_pc;
  logic        taken;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  npc_branch_unit dut_i (
    .xfer_op (xfer_op),
    .src_a   (src_a),
    .src_b   (src_b),
    .funct3  (funct3),
    .cur_pc  (cur_pc),
    .imm     (imm),
    .next_pc (next_pc),
    .taken   (taken)
  );

  task automatic apply(input logic [1:0] o, input logic [2:0] f, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] p, input logic [63:0] m);
    @(posedge clk);
    #1;
    xfer_op = o; funct3 = f; src_a = a; src_b = b; cur_pc = p; imm = m;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [63:0] en, input logic et);
    checks++;
    if (next_pc !== en || taken !== et) begin
      failures++;
      $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
               req, next_pc, taken, en, et);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: all-zero inputs give fall-through to address 4 (R1)
    expect_out("R1", 64'd4, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][VW-1 -: 2], VEC[k][VW-3 -: 3], VEC[k][320 -: 64], VEC[k][256 -: 64],
            VEC[k][192 -: 64], VEC[k][128 -: 64]);
      expect_out(TAG[k], VEC[k][64:1], VEC[k][0]);
    end

    // R1: code 0 ignores funct3 and operands that would satisfy a condition
    for (int f = 0; f < 8; f++) begin
      apply(2'd0, 3'(f), 64'd9, 64'd9, 64'h2000, 64'h100);
      expect_out("R1", 64'h2004, 1'b0);
    end
    // R2: jal ignores operands and a failing condition selector
    apply(2'd1, 3'b001, 64'd3, 64'd3, 64'h2000, 64'h100);
    expect_out("R2", 64'h2100, 1'b1);
    // R3: jalr uses the register, not the PC; even target stays even
    apply(2'd2, 3'b111, 64'h5000, 64'd0, 64'h2000, 64'h8);
    expect_out("R3", 64'h5008, 1'b1);
    // R4: bne with equal operands falls through
    apply(2'd3, 3'b001, ONES, ONES, 64'h2000, 64'h100);
    expect_out("R4", 64'h2004, 1'b0);
    // R5: blt most positive against most negative is false
    apply(2'd3, 3'b100, SMAX, SMIN, 64'h2000, 64'h100);
    expect_out("R5", 64'h2004, 1'b0);
    // R6: bgeu zero against all-ones is false, unsigned ltu of equal is false
    apply(2'd3, 3'b111, 64'd0, ONES, 64'h2000, 64'h100);
    expect_out("R6", 64'h2004, 1'b0);
    apply(2'd3, 3'b110, 64'd4, 64'd4, 64'h2000, 64'h100);
    expect_out("R6", 64'h2004, 1'b0);
    // R7: taken branch with negative offset goes backward
    apply(2'd3, 3'b000, 64'd1, 64'd1, 64'h2000, 64'hFFFF_FFFF_FFFF_FF00);
    expect_out("R7", 64'h1F00, 1'b1);
    // R9: backward branch from low PC wraps below zero
    apply(2'd3, 3'b001, 64'd1, 64'd2, 64'h8, 64'hFFFF_FFFF_FFFF_FFF0);
    expect_out("R9", 64'hFFFF_FFFF_FFFF_FFF8, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule